// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block makes the clocks for an audio serial port acting as clock master. A kernel clock is divided by a programmable factor. The factor is twice an 8-bit prescale value plus an odd-extension bit. The block drives a serial bit clock whose resting level software chooses. When asked, it also drives an oversampling master clock for an external converter. A one-cycle word strobe marks, in the kernel clock domain, the first cycle of each channel word so that a serializer can align to it.

There are two clocking modes. With the master clock off, one bit-clock period equals the divider factor, and a channel word lasts 16 or 32 bit-clock periods. With the master clock on, one master-clock period equals the divider factor. The bit clock is then derived from the master clock so that the master clock always runs at 256 times the sample rate. The derivation divides by 4 for 32-bit channel frames and by 8 for 16-bit ones. The configuration is captured only when a word begins, and a stop request lets the current word finish. Because of this, the clocks never carry a runt pulse.

Top module: `aclk_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `bclk_o`, `mclk_o` and `ws_o` are all 0 whatever `idle_hi` is.
- R2: The divider factor D equals 2*`presc`+`odd` when `presc` is 2 or more. A `presc` value of 0 or 1 gives D = 2 and the `odd` bit is ignored.
- R3: With `mck_en` = 0, `bclk_o` has a period of D kernel cycles. It sits at its active level (the inverse of `idle_hi`) for the first floor(D/2) cycles of each period, and `mclk_o` stays 0.
- R4: With `mck_en` = 1, `mclk_o` has a period of D cycles and is high for the first floor(D/2) of them. `bclk_o` has a period of 4*D (`long_frame` = 1) or 8*D (`long_frame` = 0) and is active for the first half of it. The master clock is thus 256 times the word-pair rate.
- R5: `ws_o` pulses high for one kernel cycle at the first cycle of every channel word. A word is 32 bit-clock periods when `long_frame` = 1 and 16 when it is 0. The pulse coincides with the first active phase of `bclk_o`.
- R6: While the block is stopped, `bclk_o` follows `idle_hi` one cycle later, `mclk_o` and `ws_o` are 0, and changes to `presc`, `odd`, `mck_en` and `long_frame` have no effect on the outputs.
- R7: `en` is first seen high at a rising edge while the block is stopped. The outputs are still idle after that edge, and the first word's strobe appears after the following edge.
- R8: Lowering `en` in the middle of a word lets that word run to its last cycle. After that the outputs go idle.
- R9: `presc`, `odd`, `mck_en`, `long_frame` and `idle_hi` are sampled only when a word starts. A change made during a word shapes the next word, and back-to-back words follow with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run request, acted on at word boundaries |
| presc | input | 8 | Linear prescale value |
| odd | input | 1 | Adds one kernel cycle to the divider factor |
| mck_en | input | 1 | Enables the master clock output and the 256x mode |
| long_frame | input | 1 | 1 = 32-bit channel frame, 0 = 16-bit |
| idle_hi | input | 1 | Resting level of the bit clock |
| bclk_o | output | 1 | Serial bit clock |
| mclk_o | output | 1 | Master clock (0 when disabled) |
| ws_o | output | 1 | One-cycle strobe at the start of each channel word |

## Verification
The hardest case to reach is a configuration change, or a stop request, that arrives while a word is in flight. Both must be deferred to the exact word boundary. From the ports this looks the same as an immediate change unless the word on either side is checked cycle by cycle. The stimulus holds `en` high and rewrites every configuration input a few cycles into a word. It then checks the whole old word against the old settings and the next word against the new ones, starting from its strobe. Finally it drops `en` halfway through and checks that the word completes before the outputs go idle. An exhaustive sweep over small prescale values, both odd settings, both modes, both frame lengths and both polarities covers the divider arithmetic, including the two illegal prescale values.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int PRESC_W         = 8;
  localparam int DIV_W           = PRESC_W + 1;
  localparam int BITS_SHORT      = 16;
  localparam int BITS_LONG       = 32;
  localparam int MCK_RATIO_SHORT = 8;
  localparam int MCK_RATIO_LONG  = 4;
  localparam int RAT_W           = $clog2(MCK_RATIO_SHORT);
  localparam int BIT_W           = $clog2(BITS_LONG);

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               odd;
    logic               mck;
    logic               long_frame;
    logic               idle_hi;
  } clk_cfg_t;
endpackage

// File: rtl/aclk_ratio_decode.sv
module aclk_ratio_decode
  import aclk_pkg::*;
(
  input  clk_cfg_t         cfg,
  output logic [DIV_W-1:0] div_top,
  output logic [DIV_W-1:0] div_half,
  output logic [RAT_W-1:0] rat_top,
  output logic [RAT_W-1:0] rat_half,
  output logic [BIT_W-1:0] bit_top
);
  logic [DIV_W-1:0] div;
  logic [RAT_W:0]   rat;

  always_comb begin
    // factor is {presc, odd}; too-small prescale falls back to 2
    if (cfg.presc < PRESC_W'(2)) div = DIV_W'(2);
    else                         div = {cfg.presc, cfg.odd};
    div_top  = div - DIV_W'(1);
    div_half = div >> 1;

    if (!cfg.mck)           rat = (RAT_W+1)'(1);
    else if (cfg.long_frame) rat = (RAT_W+1)'(MCK_RATIO_LONG);
    else                    rat = (RAT_W+1)'(MCK_RATIO_SHORT);
    rat_top  = RAT_W'(rat - (RAT_W+1)'(1));
    rat_half = RAT_W'(rat >> 1);

    bit_top = cfg.long_frame ? BIT_W'(BITS_LONG - 1) : BIT_W'(BITS_SHORT - 1);
  end
endmodule

// File: rtl/aclk_wrap_ctr.sv
module aclk_wrap_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] top,
  output logic [W-1:0] val,
  output logic         at_top
);
  assign at_top = (val == top);

  always_ff @(posedge clk) begin
    if (rst || clr)  val <= '0;
    else if (step)   val <= at_top ? '0 : val + W'(1);
  end

  // counter never passes its wrap value while a word is running
  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    !clr |-> (val <= top));
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [PRESC_W-1:0] presc,
  input  logic               odd,
  input  logic               mck_en,
  input  logic               long_frame,
  input  logic               idle_hi,
  output logic               bclk_o,
  output logic               mclk_o,
  output logic               ws_o
);
  clk_cfg_t         cfg_in, cfg_q;
  logic             run_q;
  logic [DIV_W-1:0] d_top, d_half, d_val;
  logic [RAT_W-1:0] r_top, r_half, r_val;
  logic [BIT_W-1:0] b_top, b_val;
  logic             d_last, r_last, b_last;
  logic             word_end, start, adv, bclk_act;

  always_comb begin
    cfg_in.presc      = presc;
    cfg_in.odd        = odd;
    cfg_in.mck        = mck_en;
    cfg_in.long_frame = long_frame;
    cfg_in.idle_hi    = idle_hi;
  end

  aclk_ratio_decode u_dec (
    .cfg(cfg_q), .div_top(d_top), .div_half(d_half),
    .rat_top(r_top), .rat_half(r_half), .bit_top(b_top)
  );

  assign word_end = run_q & d_last & r_last & b_last;
  assign start    = en & (~run_q | word_end);
  assign adv      = run_q & ~start;

  aclk_wrap_ctr #(.W(DIV_W)) u_div_ctr (
    .clk(clk), .rst(rst), .clr(start), .step(adv),
    .top(d_top), .val(d_val), .at_top(d_last)
  );

  aclk_wrap_ctr #(.W(RAT_W)) u_rat_ctr (
    .clk(clk), .rst(rst), .clr(start), .step(adv & d_last),
    .top(r_top), .val(r_val), .at_top(r_last)
  );

  aclk_wrap_ctr #(.W(BIT_W)) u_bit_ctr (
    .clk(clk), .rst(rst), .clr(start), .step(adv & d_last & r_last),
    .top(b_top), .val(b_val), .at_top(b_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cfg_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cfg_q <= cfg_in;
    end else if (word_end) begin
      run_q <= 1'b0;
    end
  end

  assign bclk_act = cfg_q.mck ? (r_val < r_half) : (d_val < d_half);

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_o <= 1'b0;
      mclk_o <= 1'b0;
      ws_o   <= 1'b0;
    end else begin
      bclk_o <= run_q ? (bclk_act ^ cfg_q.idle_hi) : idle_hi;
      mclk_o <= run_q & cfg_q.mck & (d_val < d_half);
      ws_o   <= run_q & (d_val == '0) & (r_val == '0) & (b_val == '0);
    end
  end

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    ws_o |=> !ws_o);

  assert_strobe_active_phase_R5: assert property (@(posedge clk) disable iff (rst)
    ws_o |-> (bclk_o == ~cfg_q.idle_hi));

  assert_stop_on_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> $past(d_last && r_last && b_last));

  assert_no_mclk_when_off_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.mck |=> !mclk_o);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (!ws_o && !mclk_o));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (run_q && !start) |=> $stable(cfg_q));
endmodule

// File: tb/aclk_gen_bench.sv
`timescale 1ns/1ps
module aclk_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] presc = 8'd0;
  logic       odd = 1'b0;
  logic       mck_en = 1'b0;
  logic       long_frame = 1'b0;
  logic       idle_hi = 1'b1;
  logic       bclk_o, mclk_o, ws_o;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  aclk_gen u_aclk_gen (
    .clk(clk), .rst(rst), .en(en), .presc(presc), .odd(odd),
    .mck_en(mck_en), .long_frame(long_frame), .idle_hi(idle_hi),
    .bclk_o(bclk_o), .mclk_o(mclk_o), .ws_o(ws_o)
  );

  function automatic int eff_div(int p, bit o);
    return (p < 2) ? 2 : 2 * p + o;
  endfunction

  function automatic int word_len(int d, bit m, bit l);
    int w = l ? 32 : 16;
    return m ? d * (l ? 4 : 8) * w : d * w;
  endfunction

  // expected {bclk, mclk, ws} at cycle k of a running word sequence
  function automatic logic [2:0] expect_out(int k, int d, bit m, bit l, bit pol);
    bit act, mc, ws;
    int h = d / 2;
    if (!m) begin
      act = (k % d) < h;
      mc  = 1'b0;
    end else begin
      int r = l ? 4 : 8;
      mc  = (k % d) < h;
      act = ((k / d) % r) < (r / 2);
    end
    ws = (k % word_len(d, m, l)) == 0;
    return {act ? ~pol : pol, mc, ws};
  endfunction

  task automatic check3(string req, logic [2:0] exp);
    logic [2:0] got = {bclk_o, mclk_o, ws_o};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {bclk,mclk,ws} got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic set_cfg(int p, bit o, bit m, bit l, bit pol);
    presc = 8'(p); odd = o; mck_en = m; long_frame = l; idle_hi = pol;
  endtask

  // checks one word cycle by cycle; drops en at cycle stop_at (if >= 0)
  task automatic play_word(int d, bit m, bit l, bit pol, int stop_at, string req);
    int wl = word_len(d, m, l);
    for (int k = 0; k < wl; k++) begin
      @(posedge clk); #1;
      check3(req, expect_out(k, d, m, l, pol));
      if (k == stop_at) en = 1'b0;
    end
  endtask

  task automatic run_cfg(int p, bit o, bit m, bit l, bit pol);
    int    d = eff_div(p, o);
    string req = (p < 2) ? "R2 R5" : (m ? "R4 R5" : "R3 R5");
    set_cfg(p, o, m, l, pol);
    en = 1'b1;
    @(posedge clk); #1;
    check3("R7", {pol, 1'b0, 1'b0});
    play_word(d, m, l, pol, word_len(d, m, l) / 2, req);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check3("R8", {pol, 1'b0, 1'b0});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check3("R1", 3'b000);              // in reset with idle_hi = 1
    idle_hi = 1'b0;
    rst = 1'b0;
    @(posedge clk); #1;
    check3("R1", 3'b000);

    // exhaustive sweep over small prescale values
    for (int p = 0; p < 5; p++)
      for (int o = 0; o < 2; o++)
        for (int m = 0; m < 2; m++)
          for (int l = 0; l < 2; l++)
            for (int pol = 0; pol < 2; pol++)
              run_cfg(p, o[0], m[0], l[0], pol[0]);

    // largest divider factor
    run_cfg(255, 1'b1, 1'b0, 1'b0, 1'b0);

    // mid-word reconfiguration: old word keeps old settings, next uses new
    set_cfg(3, 1'b0, 1'b0, 1'b0, 1'b0);
    en = 1'b1;
    @(posedge clk); #1;
    check3("R7", 3'b000);
    for (int k = 0; k < 96; k++) begin
      @(posedge clk); #1;
      check3("R9", expect_out(k, 6, 1'b0, 1'b0, 1'b0));
      if (k == 10) set_cfg(2, 1'b1, 1'b1, 1'b1, 1'b1);
    end
    play_word(5, 1'b1, 1'b1, 1'b1, 100, "R9 R4");
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check3("R8", 3'b100);
    end

    // stopped: bit clock tracks idle level, other inputs have no effect
    idle_hi = 1'b0;
    @(posedge clk); #1;
    check3("R6", 3'b000);
    idle_hi = 1'b1;
    @(posedge clk); #1;
    check3("R6", 3'b100);
    set_cfg(7, 1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      check3("R6", 3'b100);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule